// File: doc/BRIEF.md
# Three-Vector Launch Scan Register

This block is a row of scan cells that each hold three storage stages. A master stage (L1) and an output stage (L2) are clocked by strobes C1 and C2. In normal operation they act as a plain master-slave flip-flop from `d` to `q`. A third stage, the parking stage (L3), lets each cell keep a second test value. This supports a path delay test with three vectors, where the first and third vectors are equal.

Loading uses two scan chains that both pass through the master stages, so they must be loaded one after the other. Chain B parks the initializing value in the parking stages. Chain A then shifts the conditioning value into the output stages and leaves a copy in the masters. An external sequencer drives the outputs with the conditioning value for as long as it needs. It then pulses C3 to put the parked value on `q`, and pulses C2 to relaunch the master copy. Every stage is an enabled register on one global clock, and every strobe is a one-cycle enable.

Top module: `tvl_scan_row`

## Requirements
- R1: Asynchronous active-low reset clears every stage of every cell. After reset `q`, `so_a` and `so_b` are all zero.
- R2: Strobe C1 loads `d` into the masters. Strobe C2 copies the masters into the output stages, which drive `q` (bit i of `q` is cell i). When C1 and C2 come in the same cycle, `q` receives the previous master value.
- R3: Strobe B1 loads each master from the parking stage of the previous cell, and cell 0 takes `si_b`. Strobe B2 copies each master into its parking stage. `so_b` is the parking stage of the last cell, so the first bit shifted in ends in the last cell.
- R4: Strobe ACLK loads each master from the output stage of the previous cell, and cell 0 takes `si_a`. C2 then copies the masters to the outputs. `so_a` is the output stage of the last cell.
- R5: Chain A shifting (ACLK and C2) never changes a parking stage.
- R6: Strobe C3 copies each parking stage into its output stage, so `q` shows the parked vector.
- R7: A C2 after C3 puts the master copy left by chain A back on `q`.
- R8: If several master strobes come in the same cycle, C1 wins over ACLK, and ACLK wins over B1.
- R9: If C3 and C2 come in the same cycle, C3 wins.
- R10: A stage whose strobes are all low keeps its value. B1, B2 and ACLK alone leave `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| d | input | NCELLS | Functional data in, one bit per cell |
| q | output | NCELLS | Functional data out (output stages) |
| si_a | input | 1 | Chain A serial in |
| so_a | output | 1 | Chain A serial out |
| si_b | input | 1 | Chain B serial in |
| so_b | output | 1 | Chain B serial out |
| stb_c1 | input | 1 | Functional capture strobe into masters |
| stb_c2 | input | 1 | Master-to-output strobe |
| stb_c3 | input | 1 | Parking-to-output strobe |
| stb_a | input | 1 | Chain A load strobe into masters |
| stb_b1 | input | 1 | Chain B load strobe into masters |
| stb_b2 | input | 1 | Master-to-parking strobe |

## Verification
Each strobe takes effect at the rising edge where it is sampled high. Every output comes straight from a register, so a change is visible one edge after the strobe is applied. Values held in the masters only reach the ports through a later C2 or C3. The bench therefore checks them one cycle after that later strobe. Strobes are driven on falling edges and held for exactly one cycle. The outputs are sampled on the next falling edge, which falls after the single register on the path.

// File: rtl/tvl_scan_pkg.sv
package tvl_scan_pkg;

  // Master stage source selection; C1 beats ACLK beats B1.
  typedef enum logic [1:0] {
    MSEL_HOLD = 2'd0,
    MSEL_FUNC = 2'd1,
    MSEL_CHA  = 2'd2,
    MSEL_CHB  = 2'd3
  } msel_e;

  // Output stage source selection; C3 beats C2.
  typedef enum logic [1:0] {
    OSEL_HOLD = 2'd0,
    OSEL_MAST = 2'd1,
    OSEL_PARK = 2'd2
  } osel_e;

  function automatic msel_e master_sel(input logic c1, input logic ca,
                                       input logic b1);
    if (c1)      return MSEL_FUNC;
    else if (ca) return MSEL_CHA;
    else if (b1) return MSEL_CHB;
    else         return MSEL_HOLD;
  endfunction

  function automatic osel_e output_sel(input logic c3, input logic c2);
    if (c3)      return OSEL_PARK;
    else if (c2) return OSEL_MAST;
    else         return OSEL_HOLD;
  endfunction

  function automatic logic master_next(input msel_e s, input logic cur,
                                       input logic fd, input logic fa,
                                       input logic fb);
    case (s)
      MSEL_FUNC: return fd;
      MSEL_CHA:  return fa;
      MSEL_CHB:  return fb;
      default:   return cur;
    endcase
  endfunction

  function automatic logic output_next(input osel_e s, input logic cur,
                                       input logic fm, input logic fp);
    case (s)
      OSEL_PARK: return fp;
      OSEL_MAST: return fm;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/tvl_master_bank.sv
module tvl_master_bank
  import tvl_scan_pkg::*;
#(
  parameter int NCELLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c1,
  input  logic              ca,
  input  logic              b1,
  input  logic [NCELLS-1:0] func_in,
  input  logic [NCELLS-1:0] cha_in,
  input  logic [NCELLS-1:0] chb_in,
  output logic [NCELLS-1:0] mst
);

  msel_e sel;
  logic  ev_func_load;
  logic  ev_cha_load;
  logic  ev_chb_load;

  assign sel          = master_sel(c1, ca, b1);
  assign ev_func_load = (sel == MSEL_FUNC);
  assign ev_cha_load  = (sel == MSEL_CHA);
  assign ev_chb_load  = (sel == MSEL_CHB);

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mst[i] <= 1'b0;
      else        mst[i] <= master_next(sel, mst[i], func_in[i],
                                        cha_in[i], chb_in[i]);
    end
  end

  AST_MASTER_FUNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    c1 |=> mst == $past(func_in)); // R8
  AST_MASTER_CHA_OVER_CHB: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1 && ca) |=> mst == $past(cha_in)); // R8
  AST_MASTER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1 && !ca && !b1) |=> $stable(mst)); // R10

endmodule

// File: rtl/tvl_output_bank.sv
module tvl_output_bank
  import tvl_scan_pkg::*;
#(
  parameter int NCELLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c2,
  input  logic              c3,
  input  logic [NCELLS-1:0] mst,
  input  logic [NCELLS-1:0] park,
  output logic [NCELLS-1:0] outs
);

  osel_e sel;
  logic  ev_launch;
  logic  ev_present_park;

  assign sel             = output_sel(c3, c2);
  assign ev_launch       = (sel == OSEL_MAST);
  assign ev_present_park = (sel == OSEL_PARK);

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outs[i] <= 1'b0;
      else        outs[i] <= output_next(sel, outs[i], mst[i], park[i]);
    end
  end

  AST_OUTPUT_PARK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    c3 |=> outs == $past(park)); // R9
  AST_OUTPUT_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (c2 && !c3) |=> outs == $past(mst)); // R7
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!c2 && !c3) |=> $stable(outs)); // R10

endmodule

// File: rtl/tvl_park_bank.sv
module tvl_park_bank #(
  parameter int NCELLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b2,
  input  logic [NCELLS-1:0] mst,
  output logic [NCELLS-1:0] park
);

  logic ev_park_load;

  assign ev_park_load = b2;

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            park[i] <= 1'b0;
      else if (ev_park_load) park[i] <= mst[i];
    end
  end

  AST_PARK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !b2 |=> $stable(park)); // R5
  AST_PARK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    b2 |=> park == $past(mst)); // R3

endmodule

// File: rtl/tvl_scan_row.sv
module tvl_scan_row #(
  parameter int NCELLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCELLS-1:0] d,
  output logic [NCELLS-1:0] q,
  input  logic              si_a,
  output logic              so_a,
  input  logic              si_b,
  output logic              so_b,
  input  logic              stb_c1,
  input  logic              stb_c2,
  input  logic              stb_c3,
  input  logic              stb_a,
  input  logic              stb_b1,
  input  logic              stb_b2
);

  localparam int LAST = NCELLS - 1;

  logic [NCELLS-1:0] mst;
  logic [NCELLS-1:0] outs;
  logic [NCELLS-1:0] park;
  logic [NCELLS-1:0] cha_feed;
  logic [NCELLS-1:0] chb_feed;

  for (genvar i = 0; i < NCELLS; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign cha_feed[i] = si_a;
      assign chb_feed[i] = si_b;
    end else begin : g_link
      assign cha_feed[i] = outs[i-1];
      assign chb_feed[i] = park[i-1];
    end
  end

  tvl_master_bank #(.NCELLS(NCELLS)) u_master (
    .clk     (clk),
    .rst_n   (rst_n),
    .c1      (stb_c1),
    .ca      (stb_a),
    .b1      (stb_b1),
    .func_in (d),
    .cha_in  (cha_feed),
    .chb_in  (chb_feed),
    .mst     (mst)
  );

  tvl_output_bank #(.NCELLS(NCELLS)) u_output (
    .clk   (clk),
    .rst_n (rst_n),
    .c2    (stb_c2),
    .c3    (stb_c3),
    .mst   (mst),
    .park  (park),
    .outs  (outs)
  );

  tvl_park_bank #(.NCELLS(NCELLS)) u_park (
    .clk   (clk),
    .rst_n (rst_n),
    .b2    (stb_b2),
    .mst   (mst),
    .park  (park)
  );

  assign q    = outs;
  assign so_a = outs[LAST];
  assign so_b = park[LAST];

  AST_CHA_SHIFT_KEEPS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_a || stb_c2) && !stb_b2 |=> $stable(so_b)); // R5
  AST_SYS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_c1 && !stb_c3) ##1 (stb_c2 && !stb_c3) |=> q == $past(d, 2)); // R2

endmodule

// File: tb/tb_tvl_scan_row.sv
module tb_tvl_scan_row;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] d = '0;
  logic [N-1:0] q;
  logic         si_a = 1'b0, si_b = 1'b0;
  logic         so_a, so_b;
  logic         c1 = 0, c2 = 0, c3 = 0, ca = 0, b1 = 0, b2 = 0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tvl_scan_row #(.NCELLS(N)) dut (
    .clk(clk), .rst_n(rst_n), .d(d), .q(q),
    .si_a(si_a), .so_a(so_a), .si_b(si_b), .so_b(so_b),
    .stb_c1(c1), .stb_c2(c2), .stb_c3(c3),
    .stb_a(ca), .stb_b1(b1), .stb_b2(b2)
  );

  // strobe bits: {C1, C2, C3, ACLK, B1, B2}
  localparam logic [5:0] S_NO = 6'b000000;
  localparam logic [5:0] S_C1 = 6'b100000;
  localparam logic [5:0] S_C2 = 6'b010000;
  localparam logic [5:0] S_C3 = 6'b001000;
  localparam logic [5:0] S_CA = 6'b000100;
  localparam logic [5:0] S_B1 = 6'b000010;
  localparam logic [5:0] S_B2 = 6'b000001;

  typedef struct packed {
    logic [5:0] s;
    logic [3:0] d;
    logic       sa;
    logic       sb;
    logic [3:0] q;
    logic       oa;
    logic       ob;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    {S_C1,        4'b1010, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 capture
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b1010, 1'b1, 1'b0, 4'd2},  // R2 launch
    {S_NO,        4'b1111, 1'b1, 1'b1, 4'b1010, 1'b1, 1'b0, 4'd10}, // R10 idle
    {S_C1 | S_C2, 4'b0110, 1'b0, 1'b0, 4'b1010, 1'b1, 1'b0, 4'd2},  // R2 same cycle
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd2},  // R2
    {S_B1,        4'b0000, 1'b0, 1'b1, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3 shift B
    {S_B2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B1,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B1,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B1,        4'b0000, 1'b0, 1'b1, 4'b0110, 1'b0, 1'b0, 4'd3},  // R3
    {S_B2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b1, 4'd3},  // R3 so_b rises
    {S_CA,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b1, 4'd4},  // R4 shift A
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b1100, 1'b1, 1'b1, 4'd4},  // R4
    {S_CA,        4'b0000, 1'b1, 1'b0, 4'b1100, 1'b1, 1'b1, 4'd4},  // R4
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b1001, 1'b1, 1'b1, 4'd4},  // R4
    {S_CA,        4'b0000, 1'b1, 1'b0, 4'b1001, 1'b1, 1'b1, 4'd5},  // R5 park kept
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0011, 1'b0, 1'b1, 4'd4},  // R4
    {S_CA,        4'b0000, 1'b1, 1'b0, 4'b0011, 1'b0, 1'b1, 4'd4},  // R4
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b1, 4'd5},  // R5
    {S_NO,        4'b0000, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b1, 4'd10}, // R10 precondition
    {S_C3,        4'b0000, 1'b0, 1'b0, 4'b1001, 1'b1, 1'b1, 4'd6},  // R6 present parked
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b1, 4'd7},  // R7 relaunch
    {S_C1,        4'b1100, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b1, 4'd2},  // R2
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b1100, 1'b1, 1'b1, 4'd2},  // R2
    {S_C1 | S_CA | S_B1, 4'b0011, 1'b1, 1'b1, 4'b1100, 1'b1, 1'b1, 4'd8}, // R8
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0011, 1'b0, 1'b1, 4'd8},  // R8 C1 won
    {S_CA | S_B1, 4'b0000, 1'b0, 1'b1, 4'b0011, 1'b0, 1'b1, 4'd8},  // R8
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b1, 4'd8},  // R8 ACLK won
    {S_C3 | S_C2, 4'b0000, 1'b0, 1'b0, 4'b1001, 1'b1, 1'b1, 4'd9},  // R9 C3 won
    {S_B2,        4'b0000, 1'b0, 1'b0, 4'b1001, 1'b1, 1'b0, 4'd10}, // R10 B2 leaves q
    {S_C3,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd6},  // R6
    {S_B1,        4'b0000, 1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 4'd10}, // R10 B1 leaves q
    {S_C2,        4'b0000, 1'b0, 1'b0, 4'b1100, 1'b1, 1'b0, 4'd3}   // R3 B1 chain feed
  };

  task automatic drive(input logic [5:0] s, input logic [3:0] dv,
                       input logic a, input logic b);
    {c1, c2, c3, ca, b1, b2} = s;
    d = dv; si_a = a; si_b = b;
  endtask

  task automatic check(input int req, input logic [3:0] eq,
                       input logic eoa, input logic eob);
    checks++;
    if (q !== eq || so_a !== eoa || so_b !== eob) begin
      fails++;
      $display("FAIL R%0d: q=%b so_a=%b so_b=%b expected q=%b so_a=%b so_b=%b",
               req, q, so_a, so_b, eq, eoa, eob);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL R1: watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 4'b0000, 1'b0, 1'b0);  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].s, TBL[k].d, TBL[k].sa, TBL[k].sb);
      @(negedge clk);
      check(int'(TBL[k].req), TBL[k].q, TBL[k].oa, TBL[k].ob);
    end
    drive(S_NO, 4'b0000, 1'b0, 1'b0);
    // R1 reset mid-run clears every stage
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(S_C2, 4'b0000, 1'b0, 1'b0);  // R1 masters cleared
    @(negedge clk);
    check(1, 4'b0000, 1'b0, 1'b0);
    drive(S_C3, 4'b0000, 1'b0, 1'b0);  // R1 parking cleared
    @(negedge clk);
    check(1, 4'b0000, 1'b0, 1'b0);
    drive(S_NO, 4'b0000, 1'b0, 1'b0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule